// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two N-bit two's-complement operands and returns their full 2N-bit signed product in one combinational pass. The multiplier operand is recoded into N/2 signed radix-4 digits, each in the range -2 to +2. Every digit is read from a 3-bit window of the multiplier. Neighbouring windows share one bit, and the window at the bottom uses an implied zero below bit 0.

For each digit, a recoder drives three control lines: pick the multiplicand, pick twice the multiplicand, and negate. A row selector uses these lines to form an (N+1)-bit multiple. To negate, it inverts that multiple and injects a +1 at the row's lowest weight. The row is then sign-extended to 2N bits. Row i carries weight 4^i. An adder chain sums the N/2 rows into the product.

The width is set by the parameter N, which must be even and at least 2. Any other value stops elaboration.

Top module: `booth_mult`

## Requirements
- R1: `product` equals the signed product of `mcand_y` and `mplier_x` for every pair of input values, read as a 2N-bit two's-complement number.
- R2: The block works unchanged at N=4, N=8 and N=16. The product port is always exactly 2N bits wide.
- R3: At most one of the two multiple selections (single or double multiplicand) is active in any digit.
- R4: A window of 000 or 111 adds nothing to the product. For example, `mplier_x` = 0 gives 0, and `mplier_x` = all ones gives -`mcand_y`.
- R5: The most negative operand value -2^(N-1) is handled in either position. (-2^(N-1))·(-2^(N-1)) gives +2^(2N-2), and (-2^(N-1))·(2^(N-1)-1) gives its exact negative value.
- R6: When both operands are nonzero, bit 2N-1 of `product` equals the XOR of the operands' top bits.
- R7: A multiplier equal to 2^k (k < N-1) gives `mcand_y` sign-extended and shifted left by k bits. This shows that each digit is placed at weight 4^i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand_y | input | N | Signed multiplicand |
| mplier_x | input | N | Signed multiplier, recoded into radix-4 digits |
| product | output | 2N | Signed full-width product |

## Verification
The assertions check three things on every evaluation of the logic: that the product matches a reference multiply, that the single and double selections in each digit are mutually exclusive, and that the product sign follows from the operand signs. The bench's scenarios show the rest. These are: exhaustive coverage of all operand pairs at N=4, random coverage at N=16, the all-ones and zero multiplier cases, the most-negative-operand products, and the power-of-two multipliers that expose the placement of each digit's weight.

// File: rtl/booth_pkg.sv
package booth_pkg;

   typedef struct packed {
      logic one;   // pick the multiplicand
      logic two;   // pick twice the multiplicand
      logic neg;   // negate the chosen multiple
   } booth_ctl_t;

   // Window bits: {upper, middle, lower}
   function automatic booth_ctl_t booth_decode(input logic [2:0] win);
      booth_ctl_t c;
      c.neg = win[2];
      c.one = win[1] ^ win[0];
      c.two = (win == 3'b011) || (win == 3'b100);
      return c;
   endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
   import booth_pkg::*;
(
   input  logic [2:0]  win,
   output booth_ctl_t  ctl
);
   always_comb ctl = booth_decode(win);
endmodule

// File: rtl/booth_row_select.sv
module booth_row_select
   import booth_pkg::*;
#(
   parameter int N = 8,
   localparam int MW = N + 1,
   localparam int PW = 2 * N
) (
   input  logic [N-1:0]  mcand,
   input  booth_ctl_t    ctl,
   output logic [PW-1:0] row
);
   logic [MW-1:0] mult;
   logic [MW-1:0] flipped;

   always_comb begin
      if (ctl.two)      mult = {mcand, 1'b0};
      else if (ctl.one) mult = {mcand[N-1], mcand};
      else              mult = '0;
      flipped = mult ^ {MW{ctl.neg}};
      row     = {{(PW-MW){flipped[MW-1]}}, flipped};
   end
endmodule

// File: rtl/booth_row_sum.sv
module booth_row_sum #(
   parameter int N = 8,
   localparam int HALF = N / 2,
   localparam int PW = 2 * N
) (
   input  logic [HALF-1:0][PW-1:0] rows,
   input  logic [HALF-1:0]         negs,
   output logic [PW-1:0]           total
);
   logic [PW-1:0] acc [HALF+1];

   assign acc[0] = '0;

   for (genvar i = 0; i < HALF; i++) begin : g_acc
      logic [PW-1:0] shifted;
      logic [PW-1:0] carry_in;
      assign shifted  = rows[i] << (2 * i);
      assign carry_in = {{(PW-1){1'b0}}, negs[i]} << (2 * i);
      assign acc[i+1] = acc[i] + shifted + carry_in;
   end

   assign total = acc[HALF];
endmodule

// File: rtl/booth_mult.sv
module booth_mult
   import booth_pkg::*;
#(
   parameter int N = 8,
   localparam int HALF = N / 2,
   localparam int PW = 2 * N
) (
   input  logic [N-1:0]  mcand_y,
   input  logic [N-1:0]  mplier_x,
   output logic [PW-1:0] product
);
   if ((N % 2) != 0 || N < 2) begin : g_bad_width
      $error("booth_mult: N must be even and at least 2");
   end

   logic [HALF-1:0][PW-1:0] rows;
   logic [HALF-1:0]         dig_one;
   logic [HALF-1:0]         dig_two;
   logic [HALF-1:0]         dig_neg;

   for (genvar i = 0; i < HALF; i++) begin : g_digit
      logic [2:0] win;
      booth_ctl_t ctl;

      if (i == 0) begin : g_low
         assign win = {mplier_x[1], mplier_x[0], 1'b0};
      end else begin : g_mid
         assign win = {mplier_x[2*i+1], mplier_x[2*i], mplier_x[2*i-1]};
      end

      booth_recoder i_rec (.win(win), .ctl(ctl));

      booth_row_select #(.N(N)) i_sel (
         .mcand(mcand_y),
         .ctl  (ctl),
         .row  (rows[i])
      );

      assign dig_one[i] = ctl.one;
      assign dig_two[i] = ctl.two;
      assign dig_neg[i] = ctl.neg;
   end

   booth_row_sum #(.N(N)) i_sum (
      .rows (rows),
      .negs (dig_neg),
      .total(product)
   );
endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
   parameter int N = 8,
   localparam int HALF = N / 2,
   localparam int PW = 2 * N
) (
   input logic [N-1:0]    mcand_y,
   input logic [N-1:0]    mplier_x,
   input logic [PW-1:0]   product,
   input logic [HALF-1:0] dig_one,
   input logic [HALF-1:0] dig_two
);
   logic signed [PW-1:0] ref_p;

   always_comb begin
      ref_p = $signed(mcand_y) * $signed(mplier_x);
      if (!$isunknown({mcand_y, mplier_x})) begin
         a_r1_product_match: assert (product == ref_p)
            else $error("R1 product mismatch");
         if (mcand_y != '0 && mplier_x != '0) begin
            a_r6_sign_rule: assert (product[PW-1] == (mcand_y[N-1] ^ mplier_x[N-1]))
               else $error("R6 sign mismatch");
         end
         a_r4_zero_mplier: assert (mplier_x != '0 || product == '0)
            else $error("R4 zero multiplier gave nonzero");
         for (int i = 0; i < HALF; i++) begin
            a_r3_single_pick: assert ($onehot0({dig_one[i], dig_two[i]}))
               else $error("R3 two multiples picked");
         end
      end
   end
endmodule

bind booth_mult booth_mult_chk #(.N(N)) i_chk (
   .mcand_y (mcand_y),
   .mplier_x(mplier_x),
   .product (product),
   .dig_one (dig_one),
   .dig_two (dig_two)
);

// File: tb/test_booth_mult.sv
module test_booth_mult;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int total = 0;
   int bad = 0;

   logic [7:0]  y8, x8;
   logic [15:0] p8;
   logic [3:0]  y4, x4;
   logic [7:0]  p4;
   logic [15:0] y16, x16;
   logic [31:0] p16;

   booth_mult #(.N(8))  i_booth_mult     (.mcand_y(y8),  .mplier_x(x8),  .product(p8));
   booth_mult #(.N(4))  i_booth_mult_n4  (.mcand_y(y4),  .mplier_x(x4),  .product(p4));
   booth_mult #(.N(16)) i_booth_mult_n16 (.mcand_y(y16), .mplier_x(x16), .product(p16));

   // {multiplicand, multiplier, expected product} at N=8
   localparam logic [31:0] VEC [8] = '{
      {8'h03, 8'h05, 16'h000F},   // R1
      {8'hFD, 8'h05, 16'hFFF1},   // R1
      {8'h80, 8'h80, 16'h4000},   // R5
      {8'h7F, 8'h80, 16'hC080},   // R5
      {8'h80, 8'h7F, 16'hC080},   // R5
      {8'hFF, 8'hFF, 16'h0001},   // R4
      {8'hB3, 8'h00, 16'h0000},   // R4
      {8'h25, 8'hFF, 16'hFFDB}    // R4: all-ones multiplier gives -Y
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   initial begin
      #800000;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      y8 = '0; x8 = '0; y4 = '0; x4 = '0; y16 = '0; x16 = '0;
      repeat (3) @(negedge clk);
      check("R4 reset zero", {16'h0, p8}, 32'h0);
      check("R4 reset zero n16", p16, 32'h0);
      rst_n = 1'b1;

      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         y8 = VEC[k][31:24];
         x8 = VEC[k][23:16];
         #2;
         check("R1 table", {16'h0, p8}, {16'h0, VEC[k][15:0]});
      end

      // R2 exhaustive at N=4
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            logic signed [3:0] sa, sb;
            logic signed [7:0] e;
            @(negedge clk);
            sa = 4'(a); sb = 4'(b);
            y4 = sa; x4 = sb;
            e = sa * sb;
            #2;
            check("R2 exhaustive n4", {24'h0, p4}, {24'h0, e});
         end
      end

      // R2 random at N=16, R6 sign
      for (int n = 0; n < 300; n++) begin
         logic signed [15:0] ra, rb;
         logic signed [31:0] e;
         @(negedge clk);
         ra = 16'($urandom); rb = 16'($urandom);
         y16 = ra; x16 = rb;
         e = ra * rb;
         #2;
         check("R2 random n16", p16, e);
         if (ra != 0 && rb != 0)
            check("R6 sign n16", {31'h0, p16[31]}, {31'h0, ra[15] ^ rb[15]});
      end

      // R5 at N=16
      @(negedge clk); y16 = 16'h8000; x16 = 16'h8000; #2;
      check("R5 min*min n16", p16, 32'h4000_0000);
      @(negedge clk); y16 = 16'h8000; x16 = 16'h7FFF; #2;
      check("R5 min*max n16", p16, 32'hC000_8000);

      // R7 power-of-two multipliers at N=8
      for (int k = 0; k < 7; k++) begin
         logic signed [15:0] e;
         @(negedge clk);
         y8 = 8'hDB;
         x8 = 8'(1 << k);
         e = 16'(16'($signed(8'hDB)) <<< k);
         #2;
         check("R7 weight", {16'h0, p8}, {16'h0, e});
      end

      // R4 all-ones multiplier at N=4 and N=16
      @(negedge clk); y4 = 4'h5; x4 = 4'hF; #2;
      check("R4 ones n4", {24'h0, p4}, {24'h0, 8'hFB});
      @(negedge clk); y16 = 16'h1234; x16 = 16'hFFFF; #2;
      check("R4 ones n16", p16, 32'hFFFF_EDCC);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule